// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

The block generates four independent pulse-width modulated outputs. Each channel runs a step counter that advances once every (prescale + 1) clock cycles; a period lasts a programmable number of steps and the output is high for a programmable number of steps at the start of each period. Software programs the channels through a flat register space of strobed reads and writes, with a separate 32-byte window for each channel.

Period and high-time settings are double-buffered. A period write only stages its value. A high-time write captures the staged period and the new high time as one pending pair. The pair replaces the running settings at the next period boundary, so no period on the pin ever mixes old and new values. Prescale writes are not buffered this way and take effect at the next prescaler wrap. Disabling a channel stops it on the next clock. Enabling a channel applies any pending pair at once and starts a fresh period.

Top module: `pwm_bank`

## Requirements
- R1: Channel k decodes addresses k*32 + offset: 0x00 prescale, 0x04 period, 0x08 high time, 0x18 enable. A write reaches only the addressed channel, and a read of any other offset returns zero.
- R2: While enabled, the step counter advances once every (prescale+1) clocks and wraps after `period` steps. A period value of 0 acts as a one-step period.
- R3: Prescale uses bits [7:0], period bits [7:0], high time bits [15:0] and enable bit [0]. Upper write bits are dropped. Reads return the last value written (for enable, the current state) with upper bits zero, and rdata_o is zero whenever rd_i is low.
- R4: The output is high during steps 0 to high_time-1 and low for the rest of the period. A high time of at least the period keeps it high throughout, and a high time of 0 keeps it low.
- R5: A period write alone does not change the running waveform.
- R6: A high-time write makes the staged period and the new high time pending. The running period completes with the old settings, and the pending pair takes over from the following period.
- R7: Writing 0 to the enable bit drives the output low from the next clock and clears the step counter, without completing the running period.
- R8: Writing 1 to the enable bit of a disabled channel applies any pending pair immediately and restarts the prescaler and the step counter at 0. The output is high from that clock edge when the high time is nonzero.
- R9: Reset clears all registers and pending state, and all outputs are low.
- R10: A prescale write takes effect at the next prescaler wrap without a high-time write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 7 | Byte address: channel in [6:5], offset in [4:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when idle |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
The assertions assume that wr_i and rd_i are sampled as one-cycle strobes and that no write lands on the same channel's enable register in the cycle after a disable, since that write would legitimately change the output. With four channels filling the 7-bit address space, every address decodes to some channel. The bench changes inputs only at falling edges. It issues one register access per cycle and never raises read and write together. Between stimuli it observes each waveform for whole periods, counted from a known step-0 position.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam logic [4:0] OFS_PRE  = 5'h00;
  localparam logic [4:0] OFS_PER  = 5'h04;
  localparam logic [4:0] OFS_DUTY = 5'h08;
  localparam logic [4:0] OFS_EN   = 5'h18;

  typedef struct packed {
    logic pre;
    logic per;
    logic duty;
    logic en;
  } ch_wr_t;
endpackage

// File: rtl/pwm_bank_dec.sv
module pwm_bank_dec
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 5,
  parameter int CH_W   = 2
) (
  input  logic                      wr_i,
  input  logic [CH_W+WIN_W-1:0]     addr_i,
  output ch_wr_t [NUM_CH-1:0]       wr_o
);
  logic [CH_W-1:0]  ch;
  logic [WIN_W-1:0] ofs;
  assign ch  = addr_i[CH_W+WIN_W-1:WIN_W];
  assign ofs = addr_i[WIN_W-1:0];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hit;
    assign hit = wr_i && (ch == CH_W'(k));
    assign wr_o[k] = '{pre:  hit && (ofs == WIN_W'(OFS_PRE)),
                       per:  hit && (ofs == WIN_W'(OFS_PER)),
                       duty: hit && (ofs == WIN_W'(OFS_DUTY)),
                       en:   hit && (ofs == WIN_W'(OFS_EN))};
  end
endmodule

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q, lim_q;

  assign tick_o = run_i && (cnt_q == lim_q);

  // limit reloads only at wrap or restart, so prescale edits never cut a step short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (restart_i || tick_o) begin
      cnt_q <= '0;
      lim_q <= pre_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int PER_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_wr_t            wr_i,
  input  logic [DUTY_W-1:0] wdata_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [PER_W-1:0]  per_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              en_o,
  output logic              pwm_o
);
  localparam int CMP_W = (PER_W > DUTY_W) ? PER_W : DUTY_W;

  logic [PRE_W-1:0]  pre_q;
  logic [PER_W-1:0]  per_q, pend_per_q, act_per_q, step_q;
  logic [DUTY_W-1:0] duty_q, pend_duty_q, act_duty_q;
  logic              pend_q, en_q;
  logic              en_set, en_clr, tick, period_end;
  logic [PER_W:0]    step_nx;

  assign en_set = wr_i.en && wdata_i[0] && !en_q;
  assign en_clr = wr_i.en && !wdata_i[0];

  pwm_bank_presc #(.PRE_W(PRE_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_q),
    .restart_i(en_set || en_clr),
    .pre_i    (pre_q),
    .tick_o   (tick)
  );

  assign step_nx    = {1'b0, step_q} + 1'b1;
  assign period_end = tick && (step_nx >= {1'b0, act_per_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q       <= '0;
      per_q       <= '0;
      duty_q      <= '0;
      pend_per_q  <= '0;
      pend_duty_q <= '0;
      pend_q      <= 1'b0;
      act_per_q   <= '0;
      act_duty_q  <= '0;
      en_q        <= 1'b0;
      step_q      <= '0;
    end else begin
      if (wr_i.pre)  pre_q  <= wdata_i[PRE_W-1:0];
      if (wr_i.per)  per_q  <= wdata_i[PER_W-1:0];
      if (wr_i.duty) duty_q <= wdata_i;

      if (en_clr) begin
        en_q   <= 1'b0;
        step_q <= '0;
      end else if (en_set) begin
        en_q   <= 1'b1;
        step_q <= '0;
        if (pend_q) begin
          act_per_q  <= pend_per_q;
          act_duty_q <= pend_duty_q;
          pend_q     <= 1'b0;
        end
      end else if (tick) begin
        if (period_end) begin
          step_q <= '0;
          if (pend_q) begin
            act_per_q  <= pend_per_q;
            act_duty_q <= pend_duty_q;
            pend_q     <= 1'b0;
          end
        end else begin
          step_q <= step_nx[PER_W-1:0];
        end
      end

      // a fresh commit outranks the apply of the older pair in the same cycle
      if (wr_i.duty) begin
        pend_per_q  <= per_q;
        pend_duty_q <= wdata_i;
        pend_q      <= 1'b1;
      end
    end
  end

  assign pwm_o  = en_q && (CMP_W'(step_q) < CMP_W'(act_duty_q));
  assign pre_o  = pre_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign en_o   = en_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 5,
  parameter int PRE_W  = 8,
  parameter int PER_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  ch_wr_t [NUM_CH-1:0] ch_wr;
  logic [PRE_W-1:0]    pre_v  [NUM_CH];
  logic [PER_W-1:0]    per_v  [NUM_CH];
  logic [DUTY_W-1:0]   duty_v [NUM_CH];
  logic [NUM_CH-1:0]   en_v;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:DUTY_W];

  pwm_bank_dec #(.NUM_CH(NUM_CH), .WIN_W(WIN_W), .CH_W(CH_W)) u_dec (
    .wr_i  (wr_i),
    .addr_i(addr_i),
    .wr_o  (ch_wr)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    pwm_bank_chan #(.PRE_W(PRE_W), .PER_W(PER_W), .DUTY_W(DUTY_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ch_wr[k]),
      .wdata_i(wdata_i[DUTY_W-1:0]),
      .pre_o  (pre_v[k]),
      .per_o  (per_v[k]),
      .duty_o (duty_v[k]),
      .en_o   (en_v[k]),
      .pwm_o  (pwm_o[k])
    );
  end

  logic [CH_W-1:0]  rd_ch;
  logic [WIN_W-1:0] rd_ofs;
  assign rd_ch  = addr_i[ADDR_W-1:WIN_W];
  assign rd_ofs = addr_i[WIN_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (rd_ofs)
        WIN_W'(OFS_PRE):  rdata_o = DATA_W'(pre_v[rd_ch]);
        WIN_W'(OFS_PER):  rdata_o = DATA_W'(per_v[rd_ch]);
        WIN_W'(OFS_DUTY): rdata_o = DATA_W'(duty_v[rd_ch]);
        WIN_W'(OFS_EN):   rdata_o = DATA_W'(en_v[rd_ch]);
        default:          rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 5,
  parameter int PRE_W  = 8,
  parameter int PER_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + WIN_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] pwm_o
);
  logic [WIN_W-1:0] ofs;
  logic             unused_wdata;
  assign ofs          = addr_i[WIN_W-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  p_pre_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ofs == WIN_W'(OFS_PRE) |-> rdata_o[DATA_W-1:PRE_W] == '0);

  p_per_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ofs == WIN_W'(OFS_PER) |-> rdata_o[DATA_W-1:PER_W] == '0);

  p_duty_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ofs == WIN_W'(OFS_DUTY) |-> rdata_o[DATA_W-1:DUTY_W] == '0);

  p_en_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ofs == WIN_W'(OFS_EN) |-> rdata_o[DATA_W-1:1] == '0);

  p_hole_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ofs != WIN_W'(OFS_PRE) && ofs != WIN_W'(OFS_PER) &&
    ofs != WIN_W'(OFS_DUTY) && ofs != WIN_W'(OFS_EN) |-> rdata_o == '0);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_stop
    p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && addr_i == ADDR_W'((k << WIN_W) + int'(OFS_EN)) && !wdata_i[0]
      |=> !pwm_o[k]);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_low_r9: assert (pwm_o == '0);
    end
  end
endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH(NUM_CH), .WIN_W(WIN_W), .PRE_W(PRE_W),
  .PER_W(PER_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pwm_o  (pwm_o)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam logic [4:0] A_PRE = 5'h00, A_PER = 5'h04, A_DUTY = 5'h08, A_EN = 5'h18;
  localparam int NV = 8;
  // pre, period, high time, expected highs over two periods, period in clocks
  localparam int VEC [NV][5] = '{
    '{0, 10,   3,  6, 10},
    '{1,  8,   4, 16, 16},
    '{2,  5,   0,  0, 15},
    '{0,  6,   6, 12,  6},
    '{0,  4, 200,  8,  4},
    '{3,  3,   1,  8, 12},
    '{0,  1,   1,  2,  1},
    '{1,  7,   6, 24, 14}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o;
  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  pwm_bank dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [4:0] ofs, input logic [31:0] d);
    addr_i = 7'(ch * 32 + int'(ofs)); wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [4:0] ofs, output logic [31:0] d);
    addr_i = 7'(ch * 32 + int'(ofs)); rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic cnt_hi(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o[ch]) hi++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_o[ch];
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (pwm_o[ch] && !prev) break;
      prev = pwm_o[ch];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(pwm_o == 4'h0, "R9 outputs", pwm_o, 0);
    rd(0, A_PER, d);  check(d == 0, "R9 period reg", d, 0);
    rd(3, A_EN, d);   check(d == 0, "R9 enable reg", d, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R4 R1 table of waveforms, channel rotates
    for (int v = 0; v < NV; v++) begin
      int ch, p, h;
      bit mid;
      ch = v % 4;
      p = VEC[v][4];
      wr(ch, A_EN, 0);
      wr(ch, A_PRE, 32'(VEC[v][0]));
      wr(ch, A_PER, 32'(VEC[v][1]));
      wr(ch, A_DUTY, 32'(VEC[v][2]));
      wr(ch, A_EN, 1);
      h = 0; mid = 1'b0;
      for (int i = 0; i < 2 * p; i++) begin
        if (pwm_o[ch]) h++;
        if (i == p) mid = pwm_o[ch];
        @(negedge clk_i);
      end
      check(h == VEC[v][3], "R4 high count", h, VEC[v][3]);
      check(mid == (VEC[v][2] > 0), "R2 second period start", mid, VEC[v][2] > 0);
    end

    // R3 field masks and read-back
    wr(1, A_EN, 0);
    wr(1, A_PRE, 32'hFFFF_FFFF);   rd(1, A_PRE, d);  check(d == 32'hFF, "R3 prescale mask", d, 32'hFF);
    wr(1, A_PER, 32'h0000_1234);   rd(1, A_PER, d);  check(d == 32'h34, "R3 period mask", d, 32'h34);
    wr(1, A_DUTY, 32'h000A_BCDE);  rd(1, A_DUTY, d); check(d == 32'hBCDE, "R3 duty mask", d, 32'hBCDE);
    wr(1, A_EN, 32'hFFFF_FFFE);    rd(1, A_EN, d);   check(d == 0, "R3 enable bit0 only", d, 0);
    rd_i = 1'b0; addr_i = 7'h20; #1 check(rdata_o == 0, "R3 idle read data", rdata_o, 0);
    // R1 channel isolation and holes
    wr(2, A_PRE, 5);
    rd(1, A_PRE, d); check(d == 32'hFF, "R1 other channel kept", d, 32'hFF);
    rd(2, A_PRE, d); check(d == 5, "R1 target channel", d, 5);
    rd(2, 5'h0C, d); check(d == 0, "R1 unmapped offset", d, 0);

    // R5 R6 shadowed reload on channel 0
    wr(0, A_EN, 0);
    wr(0, A_PRE, 0); wr(0, A_PER, 10); wr(0, A_DUTY, 3); wr(0, A_EN, 1);
    wait_rise(0);
    wr(0, A_PER, 20);
    cnt_hi(0, 9, hi);  check(hi == 2, "R5 period write, rest of period", hi, 2);
    cnt_hi(0, 10, hi); check(hi == 3, "R5 period write not applied", hi, 3);
    rd(0, A_PER, d);   check(d == 20, "R5 staged read-back", d, 20);
    wr(0, A_DUTY, 15);
    cnt_hi(0, 9, hi);  check(hi == 2, "R6 running period keeps old", hi, 2);
    cnt_hi(0, 20, hi); check(hi == 15, "R6 new pair first period", hi, 15);
    cnt_hi(0, 20, hi); check(hi == 15, "R6 new pair second period", hi, 15);

    // R7 immediate stop while high
    check(pwm_o[0] == 1'b1, "R7 precondition high", pwm_o[0], 1);
    wr(0, A_EN, 0);
    check(pwm_o[0] == 1'b0, "R7 low next clock", pwm_o[0], 0);
    cnt_hi(0, 30, hi); check(hi == 0, "R7 stays low", hi, 0);
    rd(0, A_EN, d);    check(d == 0, "R7 enable reads 0", d, 0);

    // R8 enable applies pending pair with prescaler cleared
    wr(0, A_PRE, 2); wr(0, A_PER, 6); wr(0, A_DUTY, 2);
    wr(0, A_EN, 1);
    check(pwm_o[0] == 1'b1, "R8 high from enable edge", pwm_o[0], 1);
    cnt_hi(0, 18, hi); check(hi == 6, "R8 first period", hi, 6);
    cnt_hi(0, 18, hi); check(hi == 6, "R8 second period", hi, 6);

    // R10 prescale change without commit
    wr(0, A_PRE, 0);
    repeat (20) @(negedge clk_i);
    wait_rise(0);
    cnt_hi(0, 12, hi); check(hi == 4, "R10 new prescale", hi, 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule